// File: doc/BRIEF.md
# Memory Wait-State and Display Contention Controller

This block decides, for every memory cycle started by the processor or by the DMA engine, whether the cycle must be stretched and for how long. It looks at the current clock-speed code, a contention-enable control bit, a signal from the display fetcher saying that video memory is busy, and the type and address of the cycle. It answers with a registered wait request that stays high for exactly the number of cycles the access must be held.

The policy depends on the speed. At the fastest setting, every read gets one fixed wait cycle. This holds for both processor and DMA reads, and writes pass untouched. At the two middle settings nothing is ever stretched. At the base setting, legacy display contention can be switched on. An access that falls in the video window while the display is fetching is then held until the fetch ends, with a configurable upper bound. A free-running count of inserted wait cycles lets surrounding logic, or a bench, measure throughput.

Top module: `memwait_ctrl`

## Requirements
- R1: After a synchronous active-high reset, `wait_req` is low and `wait_cnt` is zero.
- R2: With speed code 3 (top), a read cycle from the processor or DMA (`cyc_write`=0) raises `wait_req` in the cycle after `cyc_start` and holds it for exactly `TOP_WAITS` cycles (default 1). This happens whatever `contend_en`, the address or `vid_fetch` are.
- R3: With speed code 3, a write cycle (`cyc_write`=1) gets no wait cycle.
- R4: With speed codes 1 or 2, `wait_req` is never raised for any cycle type.
- R5: With speed code 0, a cycle is contended when all three of these hold at `cyc_start`: `contend_en`=1, the address lies in 0x4000..0x7FFF, and `vid_fetch`=1. This applies to reads and writes alike, and to DMA when `DMA_CONTEND`=1. `wait_req` then rises in the next cycle and stays high for as many consecutive cycles as `vid_fetch` was sampled high, counting from the start cycle.
- R6: With speed code 0, a cycle gets no wait when `contend_en`=0, when the address is outside 0x4000..0x7FFF, or when `vid_fetch`=0 at the start.
- R7: A contention stall lasts at most `CONT_MAX` cycles (default 8), even if `vid_fetch` stays high.
- R8: A `cyc_start` that arrives while `wait_req` is high is ignored and neither restarts nor extends the running wait.
- R9: `wait_cnt` increases by one in the cycle after each cycle in which `wait_req` is high, wraps at its width, and otherwise holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| speed | input | 2 | Speed code: 0 base, 1 double, 2 quadruple, 3 top |
| contend_en | input | 1 | Enables display contention at the base speed |
| vid_fetch | input | 1 | Display logic is fetching video memory this cycle |
| cyc_start | input | 1 | One-cycle pulse that starts a memory cycle |
| cyc_write | input | 1 | 1 for a write cycle, 0 for a read |
| cyc_dma | input | 1 | 1 when the DMA engine owns the cycle |
| cyc_addr | input | ADDR_W | Address of the cycle |
| wait_req | output | 1 | Registered wait request to the requester |
| wait_cnt | output | CNT_W | Running count of inserted wait cycles |

## Verification
The assertions take for granted that the speed code and contention enable are stable while a cycle is starting, and that a requester does not expect a new cycle to be accepted while `wait_req` is high. They also assume `vid_fetch` is a level that the display drives cycle by cycle. The stimulus drives every input on the falling edge and pulses `cyc_start` for a single cycle. It only overlaps a start with a running wait in the one test that checks the overlap is ignored. Each vector holds `vid_fetch` high for a chosen number of cycles starting with the start cycle, so the expected stall length is known in advance.

// File: rtl/memwait_pkg.sv
package memwait_pkg;

  typedef enum logic [1:0] {
    SPD_BASE = 2'd0,
    SPD_X2   = 2'd1,
    SPD_X4   = 2'd2,
    SPD_TOP  = 2'd3
  } speed_e;

  typedef enum logic [1:0] {
    WK_NONE    = 2'd0,
    WK_FIXED   = 2'd1,
    WK_CONTEND = 2'd2
  } wkind_e;

endpackage

// File: rtl/memwait_decode.sv
module memwait_decode
  import memwait_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter logic [15:0] VID_LO      = 16'h4000,
  parameter logic [15:0] VID_HI      = 16'h7FFF,
  parameter bit          DMA_CONTEND = 1'b1
) (
  input  logic [1:0]        speed,
  input  logic              contend_en,
  input  logic              vid_fetch,
  input  logic              is_write,
  input  logic              is_dma,
  input  logic [ADDR_W-1:0] addr,
  output wkind_e            kind
);

  localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(VID_LO);
  localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(VID_HI);

  logic in_window;
  logic may_contend;

  assign in_window   = (addr >= WIN_LO) && (addr <= WIN_HI);
  assign may_contend = !is_dma || DMA_CONTEND;

  always_comb begin
    kind = WK_NONE;
    case (speed_e'(speed))
      SPD_TOP:  if (!is_write) kind = WK_FIXED;
      SPD_BASE: if (contend_en && vid_fetch && in_window && may_contend)
                  kind = WK_CONTEND;
      default:  kind = WK_NONE;
    endcase
  end

endmodule

// File: rtl/memwait_seq.sv
module memwait_seq
  import memwait_pkg::*;
#(
  parameter int TOP_WAITS = 1,
  parameter int CONT_MAX  = 8
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  wkind_e kind,
  input  logic   vid_fetch,
  output logic   wait_req
);

  localparam int REM_W = (TOP_WAITS > 1) ? $clog2(TOP_WAITS) : 1;
  localparam int STL_W = $clog2(CONT_MAX + 1);

  logic             wait_q;
  wkind_e           mode_q;
  logic [REM_W-1:0] rem_q;
  logic [STL_W-1:0] stall_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q  <= 1'b0;
      mode_q  <= WK_NONE;
      rem_q   <= '0;
      stall_q <= '0;
    end else if (!wait_q) begin
      if (start && kind != WK_NONE) begin
        wait_q  <= 1'b1;
        mode_q  <= kind;
        rem_q   <= REM_W'(TOP_WAITS - 1);
        stall_q <= STL_W'(1);
      end
    end else begin
      case (mode_q)
        WK_FIXED: begin
          if (rem_q == '0) wait_q <= 1'b0;
          else             rem_q  <= rem_q - 1'b1;
        end
        WK_CONTEND: begin
          if (!vid_fetch || stall_q == STL_W'(CONT_MAX)) wait_q <= 1'b0;
          else                                           stall_q <= stall_q + 1'b1;
        end
        default: wait_q <= 1'b0;
      endcase
    end
  end

  assign wait_req = wait_q;

  // R7
  stall_cap_chk: assert property (@(posedge clk) disable iff (rst)
    wait_q && mode_q == WK_CONTEND |-> stall_q <= STL_W'(CONT_MAX));

  // R5
  contend_release_chk: assert property (@(posedge clk) disable iff (rst)
    wait_q && mode_q == WK_CONTEND && !vid_fetch |=> !wait_q);

endmodule

// File: rtl/memwait_count.sv
module memwait_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  assign count = cnt_q;

  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    inc |=> cnt_q == $past(cnt_q) + 1'b1);

  // R9
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(cnt_q));

endmodule

// File: rtl/memwait_ctrl.sv
module memwait_ctrl
  import memwait_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          CNT_W       = 16,
  parameter int          TOP_WAITS   = 1,
  parameter int          CONT_MAX    = 8,
  parameter logic [15:0] VID_LO      = 16'h4000,
  parameter logic [15:0] VID_HI      = 16'h7FFF,
  parameter bit          DMA_CONTEND = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        speed,
  input  logic              contend_en,
  input  logic              vid_fetch,
  input  logic              cyc_start,
  input  logic              cyc_write,
  input  logic              cyc_dma,
  input  logic [ADDR_W-1:0] cyc_addr,
  output logic              wait_req,
  output logic [CNT_W-1:0]  wait_cnt
);

  wkind_e kind;

  memwait_decode #(
    .ADDR_W(ADDR_W), .VID_LO(VID_LO), .VID_HI(VID_HI), .DMA_CONTEND(DMA_CONTEND)
  ) u_decode (
    .speed(speed), .contend_en(contend_en), .vid_fetch(vid_fetch),
    .is_write(cyc_write), .is_dma(cyc_dma), .addr(cyc_addr), .kind(kind)
  );

  memwait_seq #(
    .TOP_WAITS(TOP_WAITS), .CONT_MAX(CONT_MAX)
  ) u_seq (
    .clk(clk), .rst(rst), .start(cyc_start), .kind(kind),
    .vid_fetch(vid_fetch), .wait_req(wait_req)
  );

  memwait_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .inc(wait_req), .count(wait_cnt)
  );

  // R2
  top_read_wait_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_start && !wait_req && speed == 2'd3 && !cyc_write |=> wait_req);

  // R3
  top_write_free_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_start && !wait_req && speed == 2'd3 && cyc_write |=> !wait_req);

  // R4
  mid_speed_free_chk: assert property (@(posedge clk) disable iff (rst)
    !wait_req && (speed == 2'd1 || speed == 2'd2) |=> !wait_req);

  // R6
  no_contend_off_chk: assert property (@(posedge clk) disable iff (rst)
    !wait_req && speed == 2'd0 && (!contend_en || !vid_fetch) |=> !wait_req);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> !wait_req && wait_cnt == '0);

endmodule

// File: tb/memwait_ctrl_tb.sv
module memwait_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  speed;
  logic        contend_en, vid_fetch, cyc_start, cyc_write, cyc_dma;
  logic [15:0] cyc_addr;
  logic        wait_req;
  logic [15:0] wait_cnt;

  int checks = 0;
  int bad    = 0;
  int cyc_n  = 0;

  always #2 clk = ~clk;

  memwait_ctrl u_dut (
    .clk(clk), .rst(rst), .speed(speed), .contend_en(contend_en),
    .vid_fetch(vid_fetch), .cyc_start(cyc_start), .cyc_write(cyc_write),
    .cyc_dma(cyc_dma), .cyc_addr(cyc_addr), .wait_req(wait_req),
    .wait_cnt(wait_cnt)
  );

  // {speed[2], contend_en, write, dma, addr[16], vid_fetch_len[4], expected_waits[4]}
  localparam int NV = 14;
  localparam logic [28:0] VEC [NV] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 16'h8000, 4'd0,  4'd1},  // R2 cpu read
    {2'd3, 1'b0, 1'b0, 1'b1, 16'h0000, 4'd0,  4'd1},  // R2 dma read
    {2'd3, 1'b0, 1'b1, 1'b0, 16'h8000, 4'd0,  4'd0},  // R3 write
    {2'd3, 1'b1, 1'b0, 1'b0, 16'h4000, 4'd3,  4'd1},  // R2 no contention at top
    {2'd1, 1'b1, 1'b0, 1'b0, 16'h4000, 4'd3,  4'd0},  // R4
    {2'd2, 1'b1, 1'b1, 1'b0, 16'h5000, 4'd3,  4'd0},  // R4
    {2'd0, 1'b1, 1'b0, 1'b0, 16'h4000, 4'd3,  4'd3},  // R5 read
    {2'd0, 1'b1, 1'b1, 1'b0, 16'h7FFF, 4'd2,  4'd2},  // R5 write, top edge
    {2'd0, 1'b0, 1'b0, 1'b0, 16'h4000, 4'd3,  4'd0},  // R6 disabled
    {2'd0, 1'b1, 1'b0, 1'b0, 16'h8000, 4'd3,  4'd0},  // R6 above window
    {2'd0, 1'b1, 1'b0, 1'b0, 16'h3FFF, 4'd3,  4'd0},  // R6 below window
    {2'd0, 1'b1, 1'b0, 1'b0, 16'h5000, 4'd0,  4'd0},  // R6 no fetch
    {2'd0, 1'b1, 1'b0, 1'b1, 16'h6000, 4'd1,  4'd1},  // R5 dma
    {2'd0, 1'b1, 1'b0, 1'b0, 16'h4000, 4'd12, 4'd8}   // R7 cap
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Starts one cycle, holds vid_fetch for vf cycles from the start cycle,
  // optionally repeats cyc_start at observation step again_at (0 = never).
  task automatic run_cycle(input logic [1:0] spd, input logic cen, input logic wr,
                           input logic dma, input logic [15:0] a, input int vf,
                           input int again_at, output int waits, output int cnt_delta);
    logic [15:0] c0;
    c0 = wait_cnt;
    waits = 0;
    speed = spd; contend_en = cen; cyc_write = wr; cyc_dma = dma; cyc_addr = a;
    cyc_start = 1'b1; vid_fetch = (vf > 0);
    for (int j = 1; j <= 16; j++) begin
      @(negedge clk);
      if (wait_req) waits++;
      cyc_start = (j == again_at);
      vid_fetch = (j < vf);
    end
    cnt_delta = int'(wait_cnt - c0);
  endtask

  initial begin
    int w, d;
    rst = 1'b1; speed = 2'd0; contend_en = 1'b0; vid_fetch = 1'b0;
    cyc_start = 1'b0; cyc_write = 1'b0; cyc_dma = 1'b0; cyc_addr = '0;
    repeat (3) @(negedge clk);
    check("R1 wait_req", int'(wait_req), 0);
    check("R1 wait_cnt", int'(wait_cnt), 0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [28:0] v;
      v = VEC[i];
      run_cycle(v[28:27], v[26], v[25], v[24], v[23:8], int'(v[7:4]), 0, w, d);
      check($sformatf("vector %0d waits (R2-R7 table)", i), w, int'(v[3:0]));
      check($sformatf("R9 count delta vector %0d", i), d, w);
    end

    // R2: wait appears exactly in the cycle after the start
    speed = 2'd3; cyc_write = 1'b0; cyc_start = 1'b1; cyc_addr = 16'h1234;
    @(negedge clk);
    check("R2 wait in next cycle", int'(wait_req), 1);
    cyc_start = 1'b0;
    @(negedge clk);
    check("R2 wait gone after one", int'(wait_req), 0);

    // R8: second start during a capped stall is ignored
    run_cycle(2'd0, 1'b1, 1'b0, 1'b0, 16'h4800, 15, 4, w, d);
    check("R8 ignored restart keeps cap", w, 8);

    // R1: reset during a wait clears state
    speed = 2'd0; contend_en = 1'b1; cyc_addr = 16'h4000; vid_fetch = 1'b1;
    cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0;
    check("R5 stall started", int'(wait_req), 1);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset mid-wait wait_req", int'(wait_req), 0);
    check("R1 reset mid-wait count", int'(wait_cnt), 0);
    rst = 1'b0; vid_fetch = 1'b0;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n > 100000) begin
      bad++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc_n, 100000);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule